// File: doc/BRIEF.md
# Window Command Sequencer

This engine carries out one operation on a memory device that exposes its control registers through an overlay window. A client gives it a 16-bit command code, a 32-bit data value, a 32-bit target address and a 32-bit word count. The engine then writes the control registers in a fixed order over a simple 16-bit memory bus. For buffered program commands it also reads the program-buffer pointer and streams the payload words from an input FIFO. After that it writes the execute register and polls the status register until the ready bits are set.

A per-request flag selects between two bus layouts. The first is a single 16-bit device. The second is two stacked 16-bit devices that share a 32-bit bus, where each register lives at its own address and again at that address +2. Each request ends with a one-cycle done pulse, and an error flag is raised with that pulse when polling gives up.

Top module: `win_cmd_seq`

## Requirements
- R1: `req_ready` is 1 only while the engine is idle. A request is taken when `req_valid` and `req_ready` are both 1. `req_ready` is 0 from the next cycle until done has been seen.
- R2: The register writes happen in this order: code (word offset 0x40), data (0x42), address low (0x44), address high (0x45), count low (0x48), count high (0x49). Each byte address is BASE + offset × 2 in single mode, or BASE + offset × 4 in stacked mode.
- R3: Each 32-bit argument is split into two halves. Bits 15:0 go to the low register and bits 31:16 go to the high register. In the lower copy, the data register takes data bits 15:0.
- R4: In stacked mode, all six writes are repeated at address +2 after the lower set. The repeated data write carries data bits 31:16. The code, address and count halves are the same as in the lower set.
- R5: For codes 0x00E9 and 0x00EA, the engine first reads the pointer register (offset 0x08). It then writes `count` FIFO words, in FIFO order, to byte addresses BASE + pointer + i. If the FIFO is empty it waits. All of this comes before execute. A count of 0 writes nothing.
- R6: Every other code reads no pointer and pops no FIFO word.
- R7: The execute register (offset 0x60) is written with value 1. In stacked mode it is written again at +2.
- R8: The status register (offset 0x66) is polled until bit 7 is set. In stacked mode the word at +2 is also read. It forms bits 31:16 of the status, and both bit 7 and bit 23 must be set (mask 0x00800080).
- R9: After POLL_LIMIT status evaluations that are not ready, the operation ends with `err` = 1.
- R10: `done` is a one-cycle pulse. `err` is only meaningful while `done` is 1. The engine is ready again in the cycle after the pulse.
- R11: Out of reset, `req_ready` = 1, and `mem_wr`, `mem_rd`, `buf_pop` and `done` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Engine idle, request can be taken |
| req_stacked | input | 1 | 1: two stacked 16-bit devices; 0: one device |
| req_code | input | 16 | Command code |
| req_data | input | 32 | Command data argument |
| req_addr | input | 32 | Target address argument |
| req_count | input | 32 | Word count argument |
| buf_valid | input | 1 | FIFO has a payload word |
| buf_data | input | 16 | FIFO head word |
| buf_pop | output | 1 | FIFO head consumed |
| mem_wr | output | 1 | Bus write strobe |
| mem_rd | output | 1 | Bus read strobe; data returns in the next cycle |
| mem_addr | output | AW | Bus byte address |
| mem_wdata | output | 16 | Bus write data |
| mem_rdata | input | 16 | Bus read data, valid one cycle after `mem_rd` |
| done | output | 1 | Operation finished (one cycle) |
| err | output | 1 | Polling timed out, valid with `done` |

## Verification
The assertions watch the bus and the handshakes on every cycle. They check that the engine never reports ready while it is using the bus, and that a read and a write never happen in the same cycle. They also check that a FIFO pop only happens together with a bus write of a word that is present, and that done lasts one cycle and hands back to idle. Only the bench scenarios can show the content of the sequence. That covers the exact order, addresses and halves of the register writes in both layouts, and the payload placement from the pointer while the FIFO stalls. It also covers the merged status mask where the upper device becomes ready later than the lower one, and the number of polls before a timeout.

// File: rtl/wcs_pkg.sv
package wcs_pkg;

  // word offsets of the window registers
  localparam logic [7:0] OFS_PBUF   = 8'h08;
  localparam logic [7:0] OFS_CODE   = 8'h40;
  localparam logic [7:0] OFS_DATA   = 8'h42;
  localparam logic [7:0] OFS_ADR_LO = 8'h44;
  localparam logic [7:0] OFS_ADR_HI = 8'h45;
  localparam logic [7:0] OFS_CNT_LO = 8'h48;
  localparam logic [7:0] OFS_CNT_HI = 8'h49;
  localparam logic [7:0] OFS_EXEC   = 8'h60;
  localparam logic [7:0] OFS_STAT   = 8'h66;

  localparam logic [15:0] CODE_BUF_PROG = 16'h00E9;
  localparam logic [15:0] CODE_BUF_OVWR = 16'h00EA;
  localparam logic [15:0] READY_BIT     = 16'h0080;

  localparam int unsigned NUM_FIELDS = 6;

  typedef enum logic [3:0] {
    S_IDLE, S_REGS, S_PTR, S_PTRW, S_BUF, S_EXEC, S_POLL_RD, S_POLL_LO, S_POLL_HI, S_DONE
  } wcs_state_e;

  // byte address of a window register copy
  function automatic logic [31:0] reg_addr(input logic [31:0] base, input logic [7:0] ofs,
                                           input logic wide, input logic upper);
    logic [31:0] step;
    step = wide ? 32'd4 : 32'd2;
    return base + ({24'd0, ofs} * step) + (upper ? 32'd2 : 32'd0);
  endfunction

  function automatic logic status_ready(input logic [31:0] word, input logic wide);
    logic [31:0] mask;
    mask = wide ? {READY_BIT, READY_BIT} : {16'd0, READY_BIT};
    return (word & mask) == mask;
  endfunction

  function automatic logic is_buffered(input logic [15:0] code);
    return (code == CODE_BUF_PROG) || (code == CODE_BUF_OVWR);
  endfunction

endpackage

// File: rtl/wcs_field_sel.sv
module wcs_field_sel
  import wcs_pkg::*;
(
  input  logic [2:0]  idx,
  input  logic        upper,
  input  logic [15:0] code,
  input  logic [31:0] data,
  input  logic [31:0] addr,
  input  logic [31:0] count,
  output logic [7:0]  ofs,
  output logic [15:0] word
);
  always_comb begin
    unique case (idx)
      3'd0:    begin ofs = OFS_CODE;   word = code;                              end
      3'd1:    begin ofs = OFS_DATA;   word = upper ? data[31:16] : data[15:0]; end
      3'd2:    begin ofs = OFS_ADR_LO; word = addr[15:0];                        end
      3'd3:    begin ofs = OFS_ADR_HI; word = addr[31:16];                       end
      3'd4:    begin ofs = OFS_CNT_LO; word = count[15:0];                       end
      default: begin ofs = OFS_CNT_HI; word = count[31:16];                      end
    endcase
  end
endmodule

// File: rtl/wcs_poll_eval.sv
module wcs_poll_eval
  import wcs_pkg::*;
#(
  parameter int unsigned POLL_LIMIT = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        clear,
  input  logic        eval,
  input  logic        wide,
  input  logic [31:0] word,
  output logic        ready_ok,
  output logic        expire
);
  localparam int unsigned TW = $clog2(POLL_LIMIT + 1);

  logic [TW-1:0] miss_cnt;

  assign ready_ok = status_ready(word, wide);
  assign expire   = eval && !ready_ok && (miss_cnt == TW'(POLL_LIMIT - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                miss_cnt <= '0;
    else if (clear)            miss_cnt <= '0;
    else if (eval && !ready_ok) miss_cnt <= miss_cnt + 1'b1;
  end
endmodule

// File: rtl/win_cmd_seq.sv
module win_cmd_seq
  import wcs_pkg::*;
#(
  parameter int unsigned AW         = 24,
  parameter logic [31:0] BASE       = 32'h0000_0000,
  parameter int unsigned POLL_LIMIT = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic          req_stacked,
  input  logic [15:0]   req_code,
  input  logic [31:0]   req_data,
  input  logic [31:0]   req_addr,
  input  logic [31:0]   req_count,
  input  logic          buf_valid,
  input  logic [15:0]   buf_data,
  output logic          buf_pop,
  output logic          mem_wr,
  output logic          mem_rd,
  output logic [AW-1:0] mem_addr,
  output logic [15:0]   mem_wdata,
  input  logic [15:0]   mem_rdata,
  output logic          done,
  output logic          err
);
  localparam logic [2:0] LAST_FIELD = 3'(NUM_FIELDS - 1);

  wcs_state_e  state;
  logic        wide_q, half_q, err_q;
  logic [2:0]  idx_q;
  logic [15:0] code_q, ptr_q, stat_lo_q;
  logic [31:0] data_q, addr_q, count_q, bcnt_q;

  // named internal events
  logic        accept, buf_mode, buf_end, buf_move, poll_eval, poll_ok, poll_expire;
  logic [7:0]  fld_ofs;
  logic [15:0] fld_word;
  logic [31:0] stat_word, addr_full;

  assign accept    = (state == S_IDLE) && req_valid;
  assign buf_mode  = is_buffered(code_q);
  assign buf_end   = (bcnt_q == count_q);
  assign buf_move  = (state == S_BUF) && !buf_end && buf_valid;
  assign poll_eval = ((state == S_POLL_LO) && !wide_q) || (state == S_POLL_HI);
  assign stat_word = (state == S_POLL_HI) ? {mem_rdata, stat_lo_q} : {16'd0, mem_rdata};

  wcs_field_sel u_fields (
    .idx(idx_q), .upper(half_q), .code(code_q), .data(data_q),
    .addr(addr_q), .count(count_q), .ofs(fld_ofs), .word(fld_word)
  );

  wcs_poll_eval #(.POLL_LIMIT(POLL_LIMIT)) u_poll (
    .clk(clk), .rst_n(rst_n), .clear(accept), .eval(poll_eval), .wide(wide_q),
    .word(stat_word), .ready_ok(poll_ok), .expire(poll_expire)
  );

  // bus drive
  always_comb begin
    mem_wr    = 1'b0;
    mem_rd    = 1'b0;
    mem_wdata = 16'd0;
    addr_full = BASE;
    unique case (state)
      S_REGS: begin
        mem_wr    = 1'b1;
        mem_wdata = fld_word;
        addr_full = reg_addr(BASE, fld_ofs, wide_q, half_q);
      end
      S_PTR: begin
        mem_rd    = 1'b1;
        addr_full = reg_addr(BASE, OFS_PBUF, wide_q, 1'b0);
      end
      S_BUF: begin
        mem_wr    = buf_move;
        mem_wdata = buf_data;
        addr_full = BASE + {16'd0, ptr_q} + bcnt_q;
      end
      S_EXEC: begin
        mem_wr    = 1'b1;
        mem_wdata = 16'd1;
        addr_full = reg_addr(BASE, OFS_EXEC, wide_q, half_q);
      end
      S_POLL_RD: begin
        mem_rd    = 1'b1;
        addr_full = reg_addr(BASE, OFS_STAT, wide_q, 1'b0);
      end
      S_POLL_LO: begin
        mem_rd    = wide_q;
        addr_full = reg_addr(BASE, OFS_STAT, wide_q, 1'b1);
      end
      default: ;
    endcase
  end

  assign mem_addr  = addr_full[AW-1:0];
  assign buf_pop   = buf_move;
  assign req_ready = (state == S_IDLE);
  assign done      = (state == S_DONE);
  assign err       = done && err_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= S_IDLE;
      wide_q    <= 1'b0;
      half_q    <= 1'b0;
      err_q     <= 1'b0;
      idx_q     <= '0;
      code_q    <= '0;
      data_q    <= '0;
      addr_q    <= '0;
      count_q   <= '0;
      ptr_q     <= '0;
      bcnt_q    <= '0;
      stat_lo_q <= '0;
    end else begin
      unique case (state)
        S_IDLE: if (accept) begin
          code_q  <= req_code;
          data_q  <= req_data;
          addr_q  <= req_addr;
          count_q <= req_count;
          wide_q  <= req_stacked;
          idx_q   <= '0;
          half_q  <= 1'b0;
          err_q   <= 1'b0;
          state   <= S_REGS;
        end
        S_REGS: begin
          if (idx_q == LAST_FIELD) begin
            idx_q <= '0;
            if (half_q == wide_q) begin
              half_q <= 1'b0;
              state  <= buf_mode ? S_PTR : S_EXEC;
            end else begin
              half_q <= 1'b1;
            end
          end else begin
            idx_q <= idx_q + 1'b1;
          end
        end
        S_PTR:  state <= S_PTRW;
        S_PTRW: begin
          ptr_q  <= mem_rdata;
          bcnt_q <= '0;
          state  <= S_BUF;
        end
        S_BUF: begin
          if (buf_end)       state  <= S_EXEC;
          else if (buf_move) bcnt_q <= bcnt_q + 1'b1;
        end
        S_EXEC: begin
          if (half_q == wide_q) begin
            half_q <= 1'b0;
            state  <= S_POLL_RD;
          end else begin
            half_q <= 1'b1;
          end
        end
        S_POLL_RD: state <= S_POLL_LO;
        S_POLL_LO, S_POLL_HI: begin
          if (state == S_POLL_LO) stat_lo_q <= mem_rdata;
          if (poll_eval) begin
            if (poll_ok)          state <= S_DONE;
            else if (poll_expire) begin state <= S_DONE; err_q <= 1'b1; end
            else                  state <= S_POLL_RD;
          end else begin
            state <= S_POLL_HI;
          end
        end
        S_DONE:  state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/win_cmd_seq_chk.sv
module win_cmd_seq_chk (
  input logic clk,
  input logic rst_n,
  input logic req_valid,
  input logic req_ready,
  input logic mem_wr,
  input logic mem_rd,
  input logic buf_pop,
  input logic buf_valid,
  input logic done
);
  // R1: no readiness while the bus is in use
  p_busy_no_ready_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_wr || mem_rd) |-> !req_ready);

  // R1: a taken request makes the engine busy
  p_accept_busy_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);

  // R2: one bus access per cycle
  p_one_access_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_wr && mem_rd));

  // R5: a pop moves a present word onto the bus
  p_pop_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
    buf_pop |-> (mem_wr && buf_valid));

  // R10: done lasts one cycle
  p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R10: ready again right after done
  p_done_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> req_ready);
endmodule

bind win_cmd_seq win_cmd_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .mem_wr(mem_wr), .mem_rd(mem_rd), .buf_pop(buf_pop), .buf_valid(buf_valid),
  .done(done)
);

// File: tb/tb_win_cmd_seq.sv
`timescale 1ns/1ps
module tb_win_cmd_seq;
  localparam int          AW     = 24;
  localparam logic [31:0] TBASE  = 32'h0000_1000;
  localparam int          TLIMIT = 16;
  localparam logic [15:0] PTRVAL = 16'h0200;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_stacked = 1'b0;
  logic [15:0] req_code = '0;
  logic [31:0] req_data = '0, req_addr = '0, req_count = '0;
  logic buf_valid, buf_pop, mem_wr, mem_rd, done, err, req_ready;
  logic [15:0] buf_data, mem_wdata;
  logic [15:0] mem_rdata = '0;
  logic [AW-1:0] mem_addr;

  always #4 clk = ~clk;  // 125 MHz

  win_cmd_seq #(.AW(AW), .BASE(TBASE), .POLL_LIMIT(TLIMIT)) dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_stacked(req_stacked), .req_code(req_code), .req_data(req_data),
    .req_addr(req_addr), .req_count(req_count), .buf_valid(buf_valid),
    .buf_data(buf_data), .buf_pop(buf_pop), .mem_wr(mem_wr), .mem_rd(mem_rd),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .done(done), .err(err)
  );

  int checks = 0, fails = 0, cyc = 0;

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", tag, what, act, exp);
    end
  endtask

  // window address, restated from R2/R4
  function automatic logic [31:0] win_a(input int ofs, input bit w, input bit up);
    return TBASE + ofs * (w ? 4 : 2) + (up ? 2 : 0);
  endfunction

  // device model
  int lo_after = 1, hi_after = 1, lo_reads = 0, hi_reads = 0, ptr_reads = 0;
  bit model_wide = 0;
  logic [15:0] fifo_mem [0:63];
  int fifo_wr = 0, fifo_rd = 0;
  bit stall_en = 0;

  assign buf_valid = (fifo_rd < fifo_wr) && !(stall_en && cyc[1]);
  assign buf_data  = fifo_mem[fifo_rd % 64];

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (mem_rd) begin
      if (mem_addr == win_a(8'h08, model_wide, 0)) begin
        ptr_reads <= ptr_reads + 1;
        mem_rdata <= PTRVAL;
      end else if (mem_addr == win_a(8'h66, model_wide, 0)) begin
        lo_reads  <= lo_reads + 1;
        mem_rdata <= (lo_reads + 1 >= lo_after) ? 16'h00C0 : 16'h0040;
      end else if (mem_addr == win_a(8'h66, 1, 1)) begin
        hi_reads  <= hi_reads + 1;
        mem_rdata <= (hi_reads + 1 >= hi_after) ? 16'h0081 : 16'h0001;
      end else begin
        mem_rdata <= 16'hDEAD;
      end
    end
    if (buf_pop) fifo_rd <= fifo_rd + 1;
  end

  // scoreboard
  logic [31:0] exp_a[$];
  logic [15:0] exp_d[$];
  string       exp_t[$];
  bit          exp_err = 0;
  int          done_cnt = 0;

  task automatic push_exp(input logic [31:0] a, input logic [15:0] d, input string t);
    exp_a.push_back(a); exp_d.push_back(d); exp_t.push_back(t);
  endtask

  always @(negedge clk) begin
    if (rst_n && mem_wr) begin
      if (exp_a.size() == 0) chk(0, "R2", "unexpected write addr", 32'(mem_addr), 0);
      else begin
        logic [31:0] ea; logic [15:0] ed; string et;
        ea = exp_a.pop_front(); ed = exp_d.pop_front(); et = exp_t.pop_front();
        chk(32'(mem_addr) == ea, et, "write address", 32'(mem_addr), ea);
        chk(mem_wdata == ed, et, "write data", 32'(mem_wdata), 32'(ed));
      end
    end
    if (rst_n && done) begin
      done_cnt++;
      chk(err == exp_err, exp_err ? "R9" : "R8", "err with done", 32'(err), 32'(exp_err));
      chk(exp_a.size() == 0, "R10", "writes left at done", exp_a.size(), 0);
    end
  end

  task automatic run_op(input bit w, input logic [15:0] code, input logic [31:0] d,
                        input logic [31:0] a, input logic [31:0] n, input int la,
                        input int ha, input bit e);
    bit bufd;
    int base_rd, dn0;
    bufd = (code == 16'h00E9) || (code == 16'h00EA);
    @(negedge clk);
    model_wide = w; lo_after = la; hi_after = ha;
    lo_reads = 0; hi_reads = 0; ptr_reads = 0; exp_err = e;
    base_rd = fifo_wr;
    if (bufd) for (int i = 0; i < int'(n); i++) fifo_mem[(fifo_wr + i) % 64] = 16'hB000 + 16'(i * 3 + 7);
    for (int h = 0; h <= int'(w); h++) begin
      push_exp(win_a(8'h40, w, h[0]), code, "R2");
      push_exp(win_a(8'h42, w, h[0]), h ? d[31:16] : d[15:0], h ? "R4" : "R3");
      push_exp(win_a(8'h44, w, h[0]), a[15:0], "R3");
      push_exp(win_a(8'h45, w, h[0]), a[31:16], "R3");
      push_exp(win_a(8'h48, w, h[0]), n[15:0], h ? "R4" : "R3");
      push_exp(win_a(8'h49, w, h[0]), n[31:16], h ? "R4" : "R3");
    end
    if (bufd) for (int i = 0; i < int'(n); i++)
      push_exp(TBASE + 32'(PTRVAL) + i, 16'hB000 + 16'(i * 3 + 7), "R5");
    for (int h = 0; h <= int'(w); h++) push_exp(win_a(8'h60, w, h[0]), 16'd1, "R7");
    if (bufd) fifo_wr = fifo_wr + int'(n);
    chk(req_ready == 1'b1, "R1", "ready before request", 32'(req_ready), 1);
    req_valid = 1; req_stacked = w; req_code = code; req_data = d; req_addr = a; req_count = n;
    dn0 = done_cnt;
    @(negedge clk);
    req_valid = 0;
    chk(req_ready == 1'b0, "R1", "busy after accept", 32'(req_ready), 0);
    wait (done_cnt == dn0 + 1);
    @(negedge clk);
    chk(req_ready == 1'b1, "R10", "ready after done", 32'(req_ready), 1);
    chk(done == 1'b0, "R10", "done one cycle", 32'(done), 0);
    chk(done_cnt == dn0 + 1, "R10", "done pulses", done_cnt - dn0, 1);
    if (bufd) begin
      chk(ptr_reads == 1, "R5", "pointer reads", ptr_reads, 1);
      chk(fifo_rd == fifo_wr, "R5", "fifo words consumed", fifo_rd - base_rd, n);
    end else begin
      chk(ptr_reads == 0, "R6", "pointer reads", ptr_reads, 0);
      chk(fifo_rd == base_rd, "R6", "fifo pops", fifo_rd - base_rd, 0);
    end
  endtask

  always @(posedge clk) begin
    if (cyc > 150000) begin
      fails++; checks++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
      $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(req_ready == 1'b1, "R11", "reset ready", 32'(req_ready), 1);
    chk(!mem_wr && !mem_rd && !buf_pop, "R11", "reset bus idle", {mem_wr, mem_rd, buf_pop}, 0);
    chk(done == 1'b0, "R11", "reset done", 32'(done), 0);
    rst_n = 1;
    repeat (2) @(negedge clk);

    // single device, ready at first poll
    run_op(0, 16'h0042, 32'h1234_ABCD, 32'h0005_6789, 32'd0, 1, 1, 0);
    chk(lo_reads == 1, "R8", "polls single", lo_reads, 1);
    // single device, ready at fourth poll
    run_op(0, 16'h0041, 32'hFACE_0102, 32'h00AB_CDEF, 32'd2, 4, 1, 0);
    chk(lo_reads == 4, "R8", "polls single late", lo_reads, 4);
    // stacked, upper device late
    run_op(1, 16'h0020, 32'h89AB_4567, 32'h0012_0034, 32'h0001_0002, 1, 3, 0);
    chk(hi_reads == 3, "R8", "upper polls stacked", hi_reads, 3);
    chk(lo_reads == 3, "R8", "lower polls stacked", lo_reads, 3);
    // buffered, single, with FIFO stalls
    stall_en = 1;
    run_op(0, 16'h00E9, 32'h0, 32'h0000_4000, 32'd5, 2, 1, 0);
    // buffered overwrite, stacked
    run_op(1, 16'h00EA, 32'h0, 32'h0001_0000, 32'd3, 1, 1, 0);
    stall_en = 0;
    // buffered with zero count
    run_op(0, 16'h00E9, 32'h0, 32'h0000_0010, 32'd0, 1, 1, 0);
    // timeout, single
    run_op(0, 16'h0061, 32'h0, 32'h0000_0020, 32'd0, 1000, 1, 1);
    chk(lo_reads == TLIMIT, "R9", "polls before timeout", lo_reads, TLIMIT);
    // timeout, stacked: lower ready, upper never
    run_op(1, 16'h0062, 32'h0, 32'h0000_0040, 32'd0, 1, 1000, 1);
    chk(hi_reads == TLIMIT, "R9", "upper polls before timeout", hi_reads, TLIMIT);

    repeat (3) @(negedge clk);
    $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule